// File: doc/BRIEF.md
# Variable-Strength ECC Read Controller

This block sequences read hits on a last-level cache that runs at reduced supply voltage. Each line carries two tag flags. A strength flag picks between a light single-correct/double-detect code and a heavy four-correct/five-detect code. A retire flag marks lines that must not hold data at low voltage. The heavy code needs extra parity bits. These live in a small side array with four slots per set, and the request names the slot to use. The controller starts a read of that slot when the line is heavy-coded.

One read is in flight at a time. On acceptance the block captures the request, chooses a decoder and loads a down-counter with the decoder's latency. It holds `busy` until the result pulse. Both decoders are fixed-latency models. A fault-count input stands in for the line's bit errors, and each model turns it into a clean, corrected or uncorrectable status. A retired line ends as a miss after one cycle and never touches a decoder. An uncorrectable line raises an error pulse in place of a hit.

Top module: `vs_ecc_read_ctrl`

## Requirements
- R1: After reset `busy`, `xecc_rd`, `rsp_hit`, `rsp_miss` and `rsp_err` are all 0.
- R2: A request with `req_ebit`=0 and `req_dis`=0 that is accepted at clock edge T gives its response at edge T+13: 12 base cycles plus 1 decode cycle. `rsp_strong` is 0 with it.
- R3: A request with `req_ebit`=1 and `req_dis`=0 that is accepted at edge T gives its response at edge T+27: 12 plus 15. `rsp_strong` is 1 with it.
- R4: For a heavy-coded, non-retired request, `xecc_rd` is 1 for exactly the cycle after acceptance. In that cycle `xecc_addr` = {set, slot}, with the set in the upper bits and the 2-bit slot index in the lower bits. A light-coded request never raises `xecc_rd`.
- R5: A request with `req_dis`=1 ends at edge T+1 with `rsp_miss`=1 and `rsp_hit`=0, `rsp_err`=0 and `rsp_status`=0. It does not raise `xecc_rd`, whatever `req_ebit` is.
- R6: Light-code status follows the fault count: 0 faults gives clean (`rsp_status`=2'b00), 1 gives corrected (2'b01), and 2 or more gives uncorrectable (2'b10).
- R7: Heavy-code status follows the fault count: 0 gives clean, 1 to 4 gives corrected, and 5 or more gives uncorrectable.
- R8: An uncorrectable result raises `rsp_err` with `rsp_hit` held at 0. A clean or corrected result raises `rsp_hit` with `rsp_err` at 0.
- R9: `busy` is 1 from the cycle after acceptance until the cycle before the response. While `busy` is 1, `req_valid` is ignored: it gives no extra response and no `xecc_rd`.
- R10: The response pulse lasts one cycle, and `rsp_set`/`rsp_way` echo the accepted request. A request held in the response cycle is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request, taken when `busy` is 0 |
| req_set | input | 6 | Set index |
| req_way | input | 4 | Way index |
| req_ebit | input | 1 | Line uses the heavy code |
| req_dis | input | 1 | Line is retired at low voltage |
| req_eidx | input | 2 | Side-array parity slot within the set |
| req_flt | input | 3 | Bit-fault count that the decoder models see |
| busy | output | 1 | A read is in flight |
| xecc_rd | output | 1 | Side-array parity read strobe |
| xecc_addr | output | 8 | Side-array address {set, slot} |
| rsp_hit | output | 1 | Hit data is good |
| rsp_miss | output | 1 | Retired line, treated as a miss |
| rsp_err | output | 1 | Uncorrectable error |
| rsp_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| rsp_set | output | 6 | Set of the finished request |
| rsp_way | output | 4 | Way of the finished request |
| rsp_strong | output | 1 | The heavy decoder was used |

## Verification
A wrong latency load or counter fault moves the response edge away from T+13, T+27 or T+1. Each read measures that edge to the cycle. A stale strength or retire capture shows in the same response as a wrong `rsp_strong`, a missing parity strobe, or a hit where a miss belongs. A stuck or early-clearing `busy` shows within one request: a second response or a stray `xecc_rd` appears while stimulus is held during the busy window.

// File: rtl/vsecc_pkg.sv
package vsecc_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'b00,
        ST_CORR    = 2'b01,
        ST_UNCORR  = 2'b10
    } vsecc_status_e;

    // strength selector index used by the decoder generate loop
    localparam int DEC_LIGHT = 0;
    localparam int DEC_HEAVY = 1;
    localparam int DEC_COUNT = 2;

endpackage

// File: rtl/vsecc_dec_model.sv
module vsecc_dec_model
    import vsecc_pkg::*;
#(
    parameter int FLT_W    = 3,
    parameter int CORR_CAP = 1
) (
    input  logic [FLT_W-1:0] flt,
    output vsecc_status_e    status
);
    // Fixed-latency black box: latency lives in the controller counter,
    // this only maps the fault count to a result class.
    always_comb begin
        if (flt == '0)
            status = ST_CLEAN;
        else if (flt <= FLT_W'(CORR_CAP))
            status = ST_CORR;
        else
            status = ST_UNCORR;
    end
endmodule

// File: rtl/vsecc_strength_sel.sv
module vsecc_strength_sel #(
    parameter int SET_W      = 6,
    parameter int EIDX_W     = 2,
    parameter int CNT_W      = 5,
    parameter int BASE_LAT   = 12,
    parameter int LIGHT_LAT  = 1,
    parameter int HEAVY_LAT  = 15,
    parameter int MISS_LAT   = 1
) (
    input  logic                    ebit,
    input  logic                    dis,
    input  logic [SET_W-1:0]        set,
    input  logic [EIDX_W-1:0]       eidx,
    output logic                    heavy,
    output logic                    miss,
    output logic [CNT_W-1:0]        lat,
    output logic                    xrd,
    output logic [SET_W+EIDX_W-1:0] xaddr
);
    localparam int LIGHT_TOTAL = BASE_LAT + LIGHT_LAT;
    localparam int HEAVY_TOTAL = BASE_LAT + HEAVY_LAT;

    always_comb begin
        miss  = dis;
        heavy = ebit & ~dis;
        xrd   = heavy;
        xaddr = {set, eidx};
        if (dis)
            lat = CNT_W'(MISS_LAT);
        else if (ebit)
            lat = CNT_W'(HEAVY_TOTAL);
        else
            lat = CNT_W'(LIGHT_TOTAL);
    end
endmodule

// File: rtl/vs_ecc_read_ctrl.sv
module vs_ecc_read_ctrl
    import vsecc_pkg::*;
#(
    parameter int SETS       = 64,
    parameter int WAYS       = 16,
    parameter int XSLOTS     = 4,
    parameter int FLT_W      = 3,
    parameter int BASE_LAT   = 12,
    parameter int LIGHT_LAT  = 1,
    parameter int HEAVY_LAT  = 15,
    parameter int LIGHT_CAP  = 1,
    parameter int HEAVY_CAP  = 4,
    parameter int MISS_LAT   = 1,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int EIDX_W    = $clog2(XSLOTS),
    localparam int XA_W      = SET_W + EIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SET_W-1:0]  req_set,
    input  logic [WAY_W-1:0]  req_way,
    input  logic              req_ebit,
    input  logic              req_dis,
    input  logic [EIDX_W-1:0] req_eidx,
    input  logic [FLT_W-1:0]  req_flt,
    output logic              busy,
    output logic              xecc_rd,
    output logic [XA_W-1:0]   xecc_addr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_err,
    output logic [1:0]        rsp_status,
    output logic [SET_W-1:0]  rsp_set,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_strong
);
    localparam int MAX_LAT = BASE_LAT + HEAVY_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [SET_W-1:0]  set;
        logic [WAY_W-1:0]  way;
        logic              heavy;
        logic              miss;
        logic [FLT_W-1:0]  flt;
        logic              xrd;
        logic [XA_W-1:0]   xaddr;
        logic              hit;
        logic              rmiss;
        logic              err;
        vsecc_status_e     st;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic              sel_heavy, sel_miss, sel_xrd;
    logic [CNT_W-1:0]  sel_lat;
    logic [XA_W-1:0]   sel_xaddr;
    vsecc_status_e     dec_st [DEC_COUNT];
    vsecc_status_e     fin_st;
    logic              accept;

    vsecc_strength_sel #(
        .SET_W     (SET_W),
        .EIDX_W    (EIDX_W),
        .CNT_W     (CNT_W),
        .BASE_LAT  (BASE_LAT),
        .LIGHT_LAT (LIGHT_LAT),
        .HEAVY_LAT (HEAVY_LAT),
        .MISS_LAT  (MISS_LAT)
    ) u_sel (
        .ebit  (req_ebit),
        .dis   (req_dis),
        .set   (req_set),
        .eidx  (req_eidx),
        .heavy (sel_heavy),
        .miss  (sel_miss),
        .lat   (sel_lat),
        .xrd   (sel_xrd),
        .xaddr (sel_xaddr)
    );

    // one decoder model per code strength
    for (genvar g = 0; g < DEC_COUNT; g++) begin : g_dec
        localparam int CAP = (g == DEC_HEAVY) ? HEAVY_CAP : LIGHT_CAP;
        vsecc_dec_model #(
            .FLT_W    (FLT_W),
            .CORR_CAP (CAP)
        ) u_dec (
            .flt    (s_q.flt),
            .status (dec_st[g])
        );
    end

    assign accept = req_valid & ~s_q.busy;

    always_comb begin
        if (s_q.miss)
            fin_st = ST_CLEAN;
        else if (s_q.heavy)
            fin_st = dec_st[DEC_HEAVY];
        else
            fin_st = dec_st[DEC_LIGHT];
    end

    always_comb begin
        s_d       = s_q;
        s_d.xrd   = 1'b0;
        s_d.hit   = 1'b0;
        s_d.rmiss = 1'b0;
        s_d.err   = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy  = 1'b0;
                s_d.st    = fin_st;
                s_d.rmiss = s_q.miss;
                s_d.err   = ~s_q.miss & (fin_st == ST_UNCORR);
                s_d.hit   = ~s_q.miss & (fin_st != ST_UNCORR);
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (accept) begin
            s_d.busy  = 1'b1;
            s_d.cnt   = sel_lat - 1'b1;
            s_d.set   = req_set;
            s_d.way   = req_way;
            s_d.heavy = sel_heavy;
            s_d.miss  = sel_miss;
            s_d.flt   = req_flt;
            s_d.xrd   = sel_xrd;
            s_d.xaddr = sel_xaddr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_CLEAN;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = s_q.busy;
    assign xecc_rd    = s_q.xrd;
    assign xecc_addr  = s_q.xaddr;
    assign rsp_hit    = s_q.hit;
    assign rsp_miss   = s_q.rmiss;
    assign rsp_err    = s_q.err;
    assign rsp_status = s_q.st;
    assign rsp_set    = s_q.set;
    assign rsp_way    = s_q.way;
    assign rsp_strong = s_q.heavy;

endmodule

// File: rtl/vs_ecc_read_ctrl_chk.sv
module vs_ecc_read_ctrl_chk #(
    parameter int BASE_LAT  = 12,
    parameter int LIGHT_LAT = 1,
    parameter int HEAVY_LAT = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       xecc_rd,
    input logic       rsp_hit,
    input logic       rsp_miss,
    input logic       rsp_err,
    input logic [1:0] rsp_status,
    input logic       rsp_strong
);
    localparam int LIGHT_TOTAL = BASE_LAT + LIGHT_LAT;
    localparam int HEAVY_TOTAL = BASE_LAT + HEAVY_LAT;
    localparam int W = $clog2(HEAVY_TOTAL + 2);

    logic [W-1:0] busy_len_q;
    logic         any_rsp;

    assign any_rsp = rsp_hit | rsp_miss | rsp_err;

    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_len_q <= '0;
        else if (busy)
            busy_len_q <= busy_len_q + 1'b1;
        else
            busy_len_q <= '0;
    end

    // R2
    light_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_err) && !rsp_strong |-> busy_len_q == W'(LIGHT_TOTAL));

    // R3
    heavy_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_err) && rsp_strong |-> busy_len_q == W'(HEAVY_TOTAL));

    // R4
    xrd_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xecc_rd |-> busy);

    // R5
    miss_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> !$past(xecc_rd) && rsp_status == 2'b00);

    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_err}));

    // R8
    err_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_status == 2'b10);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !xecc_rd);

    // R9
    idle_at_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_rsp |-> !busy && $past(busy));

    // R10
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_rsp |=> !(rsp_hit || rsp_miss || rsp_err));

endmodule

bind vs_ecc_read_ctrl vs_ecc_read_ctrl_chk #(
    .BASE_LAT  (BASE_LAT),
    .LIGHT_LAT (LIGHT_LAT),
    .HEAVY_LAT (HEAVY_LAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .xecc_rd    (xecc_rd),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_err    (rsp_err),
    .rsp_status (rsp_status),
    .rsp_strong (rsp_strong)
);

// File: tb/vs_ecc_read_ctrl_bench.sv
module vs_ecc_read_ctrl_bench;

    localparam int L_LIGHT = 13;
    localparam int L_HEAVY = 27;
    localparam int L_MISS  = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [5:0] req_set = '0;
    logic [3:0] req_way = '0;
    logic       req_ebit = 1'b0;
    logic       req_dis = 1'b0;
    logic [1:0] req_eidx = '0;
    logic [2:0] req_flt = '0;
    logic       busy, xecc_rd, rsp_hit, rsp_miss, rsp_err, rsp_strong;
    logic [7:0] xecc_addr;
    logic [1:0] rsp_status;
    logic [5:0] rsp_set;
    logic [3:0] rsp_way;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vs_ecc_read_ctrl u_vs_ecc_read_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .req_way(req_way), .req_ebit(req_ebit), .req_dis(req_dis),
        .req_eidx(req_eidx), .req_flt(req_flt), .busy(busy),
        .xecc_rd(xecc_rd), .xecc_addr(xecc_addr), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_err(rsp_err), .rsp_status(rsp_status),
        .rsp_set(rsp_set), .rsp_way(rsp_way), .rsp_strong(rsp_strong)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] s, input logic [3:0] w, input logic e,
                         input logic d, input logic [1:0] x, input logic [2:0] f);
        req_valid = 1'b1; req_set = s; req_way = w; req_ebit = e;
        req_dis = d; req_eidx = x; req_flt = f;
    endtask

    // waits for the response after acceptance edge; returns cycles counted
    task automatic wait_rsp(output int k, output bit busy_ok);
        k = 0;
        busy_ok = 1'b1;
        while (!(rsp_hit || rsp_miss || rsp_err) && k < 40) begin
            if (!busy) busy_ok = 1'b0;
            @(posedge clk); k++;
            @(negedge clk);
        end
    endtask

    task automatic run_read(input string req, input logic [5:0] s, input logic [3:0] w,
                            input logic e, input logic d, input logic [1:0] x,
                            input logic [2:0] f, input int exp_lat, input bit exp_hit,
                            input bit exp_miss, input bit exp_err, input int exp_st);
        int k;
        bit bok;
        bit exp_x;
        exp_x = e && !d;
        @(negedge clk);
        drive(s, w, e, d, x, f);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {req, " R9 busy after accept"}, busy, 1);
        chk(xecc_rd == exp_x, {req, " R4 parity strobe"}, xecc_rd, exp_x);
        if (exp_x)
            chk(xecc_addr == {s, x}, {req, " R4 parity address"}, xecc_addr, {s, x});
        wait_rsp(k, bok);
        chk(k == exp_lat, {req, " latency"}, k, exp_lat);
        chk(bok, {req, " R9 busy held"}, bok, 1);
        chk(rsp_hit == exp_hit && rsp_miss == exp_miss && rsp_err == exp_err,
            {req, " R8 hit/miss/err"}, {rsp_hit, rsp_miss, rsp_err},
            {exp_hit, exp_miss, exp_err});
        chk(rsp_status == exp_st, {req, " status"}, rsp_status, exp_st);
        chk(rsp_set == s && rsp_way == w, {req, " R10 echo"}, {rsp_set, rsp_way}, {s, w});
        if (!d) chk(rsp_strong == e, {req, " strength"}, rsp_strong, e);
        @(posedge clk);
        @(negedge clk);
        chk(!(rsp_hit || rsp_miss || rsp_err), {req, " R10 single pulse"},
            {rsp_hit, rsp_miss, rsp_err}, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!busy && !xecc_rd && !rsp_hit && !rsp_miss && !rsp_err, "R1 reset idle",
            {busy, xecc_rd, rsp_hit, rsp_miss, rsp_err}, 0);
    endtask

    task automatic t_light;
        run_read("R2 R6 clean",  6'd3,  4'd2, 1'b0, 1'b0, 2'd0, 3'd0, L_LIGHT, 1, 0, 0, 0);
        run_read("R2 R6 one",    6'd4,  4'd9, 1'b0, 1'b0, 2'd1, 3'd1, L_LIGHT, 1, 0, 0, 1);
        run_read("R6 R8 two",    6'd5,  4'd0, 1'b0, 1'b0, 2'd2, 3'd2, L_LIGHT, 0, 0, 1, 2);
    endtask

    task automatic t_heavy;
        run_read("R3 R7 clean",  6'd10, 4'd1, 1'b1, 1'b0, 2'd2, 3'd0, L_HEAVY, 1, 0, 0, 0);
        run_read("R3 R7 four",   6'd63, 4'd15, 1'b1, 1'b0, 2'd3, 3'd4, L_HEAVY, 1, 0, 0, 1);
        run_read("R7 R8 five",   6'd20, 4'd7, 1'b1, 1'b0, 2'd1, 3'd5, L_HEAVY, 0, 0, 1, 2);
        run_read("R7 seven",     6'd0,  4'd0, 1'b1, 1'b0, 2'd0, 3'd7, L_HEAVY, 0, 0, 1, 2);
    endtask

    task automatic t_disabled;
        run_read("R5 light dis", 6'd8,  4'd3, 1'b0, 1'b1, 2'd0, 3'd3, L_MISS, 0, 1, 0, 0);
        run_read("R5 heavy dis", 6'd9,  4'd4, 1'b1, 1'b1, 2'd3, 3'd0, L_MISS, 0, 1, 0, 0);
    endtask

    task automatic t_busy_ignore;
        int k;
        bit bok;
        int extra;
        int stray;
        @(negedge clk);
        drive(6'd12, 4'd6, 1'b0, 1'b0, 2'd0, 3'd0);
        @(posedge clk);
        @(negedge clk);
        drive(6'd33, 4'd11, 1'b1, 1'b0, 2'd2, 3'd0);
        stray = 0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (xecc_rd) stray++;
        end
        req_valid = 1'b0;
        chk(stray == 0, "R9 no strobe while busy", stray, 0);
        wait_rsp(k, bok);
        chk(k == L_LIGHT - 6, "R9 first response timing", k, L_LIGHT - 6);
        chk(rsp_set == 6'd12 && rsp_way == 4'd6, "R9 kept first request",
            {rsp_set, rsp_way}, {6'd12, 4'd6});
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rsp_hit || rsp_miss || rsp_err || busy) extra++;
        end
        chk(extra == 0, "R9 ignored request gave no response", extra, 0);
    endtask

    task automatic t_back_to_back;
        int k;
        bit bok;
        @(negedge clk);
        drive(6'd1, 4'd1, 1'b0, 1'b1, 2'd0, 3'd0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp(k, bok);
        chk(rsp_miss == 1'b1, "R10 first miss", rsp_miss, 1);
        drive(6'd2, 4'd5, 1'b1, 1'b0, 2'd1, 3'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1 && xecc_rd == 1'b1, "R10 accepted in response cycle",
            {busy, xecc_rd}, 3);
        chk(xecc_addr == {6'd2, 2'd1}, "R4 back-to-back address", xecc_addr, {6'd2, 2'd1});
        wait_rsp(k, bok);
        chk(k == L_HEAVY && rsp_hit && rsp_strong, "R3 R10 second response",
            k, L_HEAVY);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_light();
        t_heavy();
        t_disabled();
        t_busy_ignore();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule